// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register interface between a host bus and the embedded processor of a classic PC keyboard controller. The host writes bytes into an input register and reads bytes from an output register. The embedded side does the reverse. A status byte shows whether each direction holds an unconsumed byte. It also records whether the last host byte was a command or data, taken from the address line that the host used for the write.

Two interrupt request lines, one for the keyboard and one for the mouse, leave the block. At first each line simply copies a port bit that the embedded side writes. After a one-way flag mode command, each port bit becomes an enable. The keyboard line then shows that an output byte is waiting. The mouse line shows that the input register has been emptied.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, both interrupt lines are 0 and flag mode is off.
- R2: A host write loads the input register, sets the input-full flag (status bit 1) and copies the address select into status bit 3 (1 = command, 0 = data). The byte and the bit are visible on the embedded side.
- R3: An embedded read of the input register clears the input-full flag. If a host write falls in the same cycle, the flag stays set.
- R4: An embedded write loads the output register and sets the output-full flag (status bit 0). A host read with address select 0 returns the output register and clears that flag.
- R5: When a host output read and an embedded output write fall in the same cycle, the host receives the previous byte, the output-full flag stays 1 and the new byte is kept.
- R6: A host read with address select 1 returns the status byte: bit 0 output-full, bit 1 input-full, bit 3 command flag, all other bits 0. It changes no flag.
- R7: Outside flag mode, the keyboard line equals port bit 0 and the mouse line equals port bit 1, as last written by the embedded side.
- R8: In flag mode the keyboard line equals the output-full flag when port bit 0 is 1, and is 0 otherwise.
- R9: In flag mode the mouse line equals the inverse of the input-full flag when port bit 1 is 1, and is 0 otherwise.
- R10: Flag mode, once entered, stays on; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostA2 | input | 1 | Host address select: 1 = status/command, 0 = data |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte (status or output register) |
| ctlRdIn | input | 1 | Embedded read of input register |
| ctlInData | output | 8 | Input register contents |
| ctlInCmd | output | 1 | Command flag of the last host write |
| ctlWrOut | input | 1 | Embedded write of output register |
| ctlOutData | input | 8 | Byte for the output register |
| ctlPortWr | input | 1 | Embedded write of interrupt port bits |
| ctlPortData | input | 2 | Bit 0 keyboard, bit 1 mouse |
| ctlFlagEn | input | 1 | Pulse that enters flag mode |
| ctlStatus | output | 8 | Status byte seen by the embedded side |
| kbdIrq | output | 1 | Keyboard interrupt request |
| mouseIrq | output | 1 | Mouse interrupt request |

## Verification
Two pairs of events can fall in the same cycle and compete for a flag. One pair is a host write together with an embedded read of the input register. The other is a host output read together with an embedded output write. The bench issues both strobes of each pair in one cycle. It then judges the outcome from the status byte, the byte the host received in that cycle, and the byte a later host read returns. The interrupt gating is swept over every combination of port bits and buffer flags in both modes.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  // Load strobes passed from control to datapath
  typedef struct packed {
    logic loadIn;
    logic loadOut;
    logic loadPort;
  } dpStrobes_t;
endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostA2,
  input  logic       ctlRdIn,
  input  logic       ctlWrOut,
  input  logic       ctlPortWr,
  input  logic       ctlFlagEn,
  output dpStrobes_t strobes,
  output logic       ibf,
  output logic       obf,
  output logic       flagMode
);
  logic clrIbf, clrObf;

  always_comb begin
    strobes.loadIn   = hostWr;
    strobes.loadOut  = ctlWrOut;
    strobes.loadPort = ctlPortWr;
    clrIbf = ctlRdIn && !hostWr;
    clrObf = hostRd && !hostA2 && !ctlWrOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf      <= 1'b0;
      obf      <= 1'b0;
      flagMode <= 1'b0;
    end else begin
      if (hostWr)      ibf <= 1'b1;
      else if (clrIbf) ibf <= 1'b0;
      if (ctlWrOut)    obf <= 1'b1;
      else if (clrObf) obf <= 1'b0;
      if (ctlFlagEn)   flagMode <= 1'b1;
    end
  end

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> ibf);
  // R3
  ibf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdIn && !hostWr) |=> !ibf);
  // R4
  obf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrOut |=> obf);
  // R6
  status_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostA2 && !hostWr && !ctlWrOut && !ctlRdIn)
      |=> (ibf == $past(ibf)) && (obf == $past(obf)));
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagMode |=> flagMode);
endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              hostA2,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] ctlOutData,
  input  logic [1:0]        ctlPortData,
  input  logic              ibf,
  input  logic              obf,
  input  logic              flagMode,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] ctlInData,
  output logic              ctlInCmd,
  output logic [DATA_W-1:0] statusByte,
  output logic              kbdIrq,
  output logic              mouseIrq
);
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;
  localparam int CMD_POS = 3;

  logic [DATA_W-1:0] inReg, outReg;
  logic              cmdReg;
  logic [1:0]        portReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg   <= '0;
      outReg  <= '0;
      cmdReg  <= 1'b0;
      portReg <= 2'b00;
    end else begin
      if (strobes.loadIn) begin
        inReg  <= hostWrData;
        cmdReg <= hostA2;
      end
      if (strobes.loadOut)  outReg  <= ctlOutData;
      if (strobes.loadPort) portReg <= ctlPortData;
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[OBF_POS] = obf;
    statusByte[IBF_POS] = ibf;
    statusByte[CMD_POS] = cmdReg;
  end

  assign hostRdData = hostA2 ? statusByte : outReg;
  assign ctlInData  = inReg;
  assign ctlInCmd   = cmdReg;
  assign kbdIrq     = flagMode ? (portReg[0] & obf)  : portReg[0];
  assign mouseIrq   = flagMode ? (portReg[1] & ~ibf) : portReg[1];

  // R2
  cmd_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIn |=> (ctlInCmd == $past(hostA2)) && (ctlInData == $past(hostWrData)));
  // R8
  kbd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagMode && !obf) |-> !kbdIrq);
  // R9
  mouse_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagMode && ibf) |-> !mouseIrq);
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostA2,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              ctlRdIn,
  output logic [DATA_W-1:0] ctlInData,
  output logic              ctlInCmd,
  input  logic              ctlWrOut,
  input  logic [DATA_W-1:0] ctlOutData,
  input  logic              ctlPortWr,
  input  logic [1:0]        ctlPortData,
  input  logic              ctlFlagEn,
  output logic [DATA_W-1:0] ctlStatus,
  output logic              kbdIrq,
  output logic              mouseIrq
);
  dpStrobes_t strobes;
  logic ibf, obf, flagMode;

  kbc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostA2(hostA2),
    .ctlRdIn(ctlRdIn), .ctlWrOut(ctlWrOut), .ctlPortWr(ctlPortWr),
    .ctlFlagEn(ctlFlagEn), .strobes(strobes), .ibf(ibf), .obf(obf),
    .flagMode(flagMode)
  );

  kbc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostA2(hostA2),
    .hostWrData(hostWrData), .ctlOutData(ctlOutData), .ctlPortData(ctlPortData),
    .ibf(ibf), .obf(obf), .flagMode(flagMode), .hostRdData(hostRdData),
    .ctlInData(ctlInData), .ctlInCmd(ctlInCmd), .statusByte(ctlStatus),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq)
  );

  // R1
  reset_irq_chk: assert property (@(posedge clk)
    !rstN |=> (!kbdIrq && !mouseIrq && ctlStatus == '0));
endmodule

// File: tb/kbc_mailbox_tb_top.sv
module kbc_mailbox_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostA2 = 0, hostWr = 0, hostRd = 0, ctlRdIn = 0, ctlWrOut = 0;
  logic ctlPortWr = 0, ctlFlagEn = 0;
  logic [7:0] hostWrData = 0, ctlOutData = 0;
  logic [1:0] ctlPortData = 0;
  logic [7:0] hostRdData, ctlInData, ctlStatus;
  logic ctlInCmd, kbdIrq, mouseIrq;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbc_mailbox dut_i (
    .clk(clk), .rstN(rstN), .hostA2(hostA2), .hostWr(hostWr), .hostRd(hostRd),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .ctlRdIn(ctlRdIn),
    .ctlInData(ctlInData), .ctlInCmd(ctlInCmd), .ctlWrOut(ctlWrOut),
    .ctlOutData(ctlOutData), .ctlPortWr(ctlPortWr), .ctlPortData(ctlPortData),
    .ctlFlagEn(ctlFlagEn), .ctlStatus(ctlStatus), .kbdIrq(kbdIrq),
    .mouseIrq(mouseIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge, then release every strobe
  task automatic step();
    @(posedge clk); #1;
    hostWr = 0; hostRd = 0; ctlRdIn = 0; ctlWrOut = 0; ctlPortWr = 0; ctlFlagEn = 0;
  endtask

  function automatic logic [7:0] statExp(logic o, logic i, logic c);
    return {4'b0, c, 1'b0, i, o};
  endfunction

  logic expObf, expIbf, expCmd, expFlag;
  logic [1:0] expPort;

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1; #1;
    // R1
    check("R1 status", ctlStatus, 8'h00);
    check("R1 irqs", {kbdIrq, mouseIrq}, 2'b00);
    ctlPortData = 2'b01; ctlPortWr = 1; step();
    check("R1 flag mode off (kbd follows port)", kbdIrq, 1'b1);
    ctlPortData = 2'b00; ctlPortWr = 1; step();

    // R2 / R3 / R6 sweep over bytes and address select
    for (int b = 0; b < 16; b++) begin
      logic [7:0] v;
      v = 8'(b * 37 + 5);
      hostA2 = b[0]; hostWrData = v; hostWr = 1; step();
      check("R2 in byte", ctlInData, v);
      check("R2 cmd flag", ctlInCmd, b[0]);
      hostA2 = 1; hostRd = 1; #1;
      check("R6 status read", hostRdData, statExp(0, 1, b[0]));
      step();
      check("R6 read keeps flags", ctlStatus, statExp(0, 1, b[0]));
      ctlRdIn = 1; step();
      check("R3 ibf cleared", ctlStatus[1], 1'b0);
    end

    // R3 collision: host write and embedded read together
    hostA2 = 0; hostWrData = 8'hA5; hostWr = 1; step();
    hostWrData = 8'h5A; hostWr = 1; ctlRdIn = 1; step();
    check("R3 collision ibf stays", ctlStatus[1], 1'b1);
    check("R3 collision new byte", ctlInData, 8'h5A);
    ctlRdIn = 1; step();

    // R4 output path
    for (int b = 0; b < 8; b++) begin
      logic [7:0] v;
      v = 8'(b * 29 + 3);
      ctlOutData = v; ctlWrOut = 1; step();
      check("R4 obf set", ctlStatus[0], 1'b1);
      hostA2 = 0; hostRd = 1; #1;
      check("R4 host data read", hostRdData, v);
      step();
      check("R4 obf cleared", ctlStatus[0], 1'b0);
    end

    // R5 collision: host read and embedded write together
    ctlOutData = 8'h11; ctlWrOut = 1; step();
    ctlOutData = 8'h22; ctlWrOut = 1; hostA2 = 0; hostRd = 1; #1;
    check("R5 host gets old byte", hostRdData, 8'h11);
    step();
    check("R5 obf stays", ctlStatus[0], 1'b1);
    hostRd = 1; #1;
    check("R5 new byte kept", hostRdData, 8'h22);
    step();

    // R7/R8/R9 sweep: mode x port bits x obf x ibf
    for (int m = 0; m < 2; m++) begin
      if (m == 1) begin ctlFlagEn = 1; step(); end
      for (int p = 0; p < 4; p++) begin
        for (int o = 0; o < 2; o++) begin
          for (int i = 0; i < 2; i++) begin
            ctlPortData = 2'(p); ctlPortWr = 1; step();
            if (o == 1) ctlWrOut = 1; else begin hostA2 = 0; hostRd = 1; end
            step();
            if (i == 1) hostWr = 1; else ctlRdIn = 1;
            step();
            if (m == 0) begin
              check("R7 kbd follows port", kbdIrq, p[0]);
              check("R7 mouse follows port", mouseIrq, p[1]);
            end else begin
              check("R8 kbd gated", kbdIrq, p[0] & o[0]);
              check("R9 mouse gated", mouseIrq, p[1] & ~i[0]);
            end
          end
        end
      end
    end

    // R10 flag mode persists; only reset clears
    ctlPortData = 2'b01; ctlPortWr = 1; step();
    hostA2 = 0; hostRd = 1; step();
    repeat (5) step();
    check("R10 still in flag mode", kbdIrq, 1'b0);
    rstN = 0; step(); rstN = 1;
    ctlPortData = 2'b01; ctlPortWr = 1; step();
    check("R10 reset leaves flag mode", kbdIrq, 1'b1);
    check("R1 status after reset", ctlStatus, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule